// File: doc/BRIEF.md
# Static Three-Digit Segment Display Loader

This block turns a three-digit decimal number into the segment patterns of a static seven-segment display. Each digit has its own 8-bit hold register. The hold register keeps its pattern on its outputs with no refresh, so the digits are never scanned. All three registers take their data from one shared segment bus. A sequencer places a digit's pattern on that bus and then raises that digit's load strobe. A register takes in the bus only on the rising edge of its own strobe.

A one-cycle start pulse copies the three BCD inputs into the block and begins a write pass. The pass writes the hundreds digit first, then the tens digit, then the units digit. Each digit goes through three phases of one clock cycle each:

- data setup: the pattern is on the bus and the strobe is low
- strobe high: the strobe is raised while the bus holds the pattern
- release: the strobe is lowered and the bus still holds the pattern

After the units digit, the block raises a one-cycle done flag. The bus does not change again until the next pass.

Top module: `seg3_latch_updater`

## Requirements
- R1: BCD codes 0 to 9 give active-high patterns with segment a in bit 0 through segment g in bit 6, and bit 7 always 0. In hex, codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R2: BCD codes 10 to 15 give a pattern with all segments off (00).
- R3: Let E0 be the clock edge at which a start pulse is accepted. The hundreds output takes its new pattern at the 2nd edge after E0, the tens output at the 5th and the units output at the 8th. Outputs are never written in any other order.
- R4: A hold register loads the bus value only when its strobe goes from low to high. While its strobe stays high, or stays low, its output does not change.
- R5: A digit that is not being strobed keeps its previous pattern, even while the shared bus carries data for another digit.
- R6: At most one strobe is high at a time. The bus value is the same in the cycle before a strobe rises, in the strobe's high cycle, and in the cycle in which the strobe falls.
- R7: While rst_n is low, all segment outputs and done are 0. The reset takes effect at once, without waiting for a clock edge. Without a reset, the outputs keep their patterns for as long as no new pass runs.
- R8: A start pulse that arrives during a pass is ignored. It does not change the digits being written and does not cause an extra pass or an extra done pulse.
- R9: done is high for exactly one cycle, starting at the 9th edge after E0.
- R10: The BCD inputs are sampled only at E0. Changes to them during the pass do not affect the patterns written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low clear. Takes effect at once; its release is synchronized to clk |
| start | input | 1 | One-cycle request to write the BCD inputs to the display |
| hund_bcd | input | 4 | Hundreds digit, BCD |
| tens_bcd | input | 4 | Tens digit, BCD |
| unit_bcd | input | 4 | Units digit, BCD |
| hund_seg | output | 8 | Pattern held for the hundreds digit (bit 0 = a ... bit 6 = g, bit 7 = 0) |
| tens_seg | output | 8 | Pattern held for the tens digit |
| unit_seg | output | 8 | Pattern held for the units digit |
| done | output | 1 | One-cycle pulse after the units digit has been loaded |

## Verification
The hardest case to reach from the ports is the cycle in which the shared bus already carries the new tens pattern and the tens strobe is high, while the hundreds and units registers must keep their values. A second hard case is a start pulse that arrives during a pass, carrying different digits. The bench times every check, and the start pulse injected during a pass, to a counted falling clock edge after the accepting edge. It compares the untouched digits against their previous values at those exact cycles. It also changes the BCD inputs and resets the block in the middle of a pass.

// File: rtl/seg3_pkg.sv
package seg3_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 8;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RELEASE = 2'd3
  } phase_e;
endpackage

// File: rtl/seg3_encoder.sv
module seg3_encoder
  import seg3_pkg::*;
(
  input  bcd_t bcd_i,
  input  logic blank_i,
  output seg_t seg_o
);
  logic [6:0] pat;

  // bit 0 = a ... bit 6 = g
  always_comb begin
    case (bcd_i)
      4'd0:    pat = 7'b0111111;
      4'd1:    pat = 7'b0000110;
      4'd2:    pat = 7'b1011011;
      4'd3:    pat = 7'b1001111;
      4'd4:    pat = 7'b1100110;
      4'd5:    pat = 7'b1101101;
      4'd6:    pat = 7'b1111101;
      4'd7:    pat = 7'b0000111;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1101111;
      default: pat = 7'b0000000;
    endcase
  end

  always_comb begin
    if (blank_i) seg_o = '0;
    else         seg_o = {1'b0, pat};
  end
endmodule

// File: rtl/seg3_hold_reg.sv
module seg3_hold_reg
  import seg3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  seg_t bus_i,
  output seg_t q_o
);
  logic strobe_d;
  logic load_en;
  seg_t q_r;
  seg_t q_n;

  assign load_en = strobe_i & ~strobe_d;

  always_comb begin
    q_n = q_r;
    if (load_en) q_n = bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      q_r      <= '0;
    end else begin
      strobe_d <= strobe_i;
      q_r      <= q_n;
    end
  end

  assign q_o = q_r;

  // R4
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(q_o));

  // R4
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && strobe_d) |=> $stable(q_o));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !strobe_d) |=> (q_o == $past(bus_i)));
endmodule

// File: rtl/seg3_sequencer.sv
module seg3_sequencer
  import seg3_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [NUM_DIGITS-1:0][BCD_W-1:0]  bcd_i,
  output bcd_t                              sel_bcd_o,
  output logic                              bus_on_o,
  output logic [NUM_DIGITS-1:0]             strobe_o,
  output logic                              done_o
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  phase_e                            phase_q, phase_n;
  logic [IDX_W-1:0]                  idx_q, idx_n;
  logic [NUM_DIGITS-1:0][BCD_W-1:0]  bcd_q;
  logic                              cap_en;
  logic                              done_q, done_n;

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    cap_en  = 1'b0;
    done_n  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_n = PH_SETUP;
          idx_n   = '0;
          cap_en  = 1'b1;
        end
      end
      PH_SETUP:  phase_n = PH_STROBE;
      PH_STROBE: phase_n = PH_RELEASE;
      PH_RELEASE: begin
        if (idx_q == LAST_IDX) begin
          phase_n = PH_IDLE;
          done_n  = 1'b1;
        end else begin
          phase_n = PH_SETUP;
          idx_n   = idx_q + IDX_W'(1);
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bcd_q <= '0;
    else if (cap_en) bcd_q <= bcd_i;
  end

  assign sel_bcd_o = bcd_q[idx_q];
  assign bus_on_o  = (phase_q != PH_IDLE);
  assign done_o    = done_q;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_strobe
    assign strobe_o[g] = (phase_q == PH_STROBE) && (idx_q == IDX_W'(g));
  end

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o));

  // R6
  setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe_o) |-> ($stable(sel_bcd_o) && $past(bus_on_o)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|strobe_o) |-> ($stable(sel_bcd_o) && bus_on_o));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(bcd_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/seg3_latch_updater.sv
module seg3_latch_updater
  import seg3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] hund_bcd,
  input  logic [3:0] tens_bcd,
  input  logic [3:0] unit_bcd,
  output logic [7:0] hund_seg,
  output logic [7:0] tens_seg,
  output logic [7:0] unit_seg,
  output logic       done
);
  localparam int NUM_DIGITS = 3;
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]            rst_pipe;
  logic                              rst_int_n;
  logic [NUM_DIGITS-1:0][BCD_W-1:0]  bcd_vec;
  bcd_t                              sel_bcd;
  logic                              bus_on;
  logic [NUM_DIGITS-1:0]             strobe;
  seg_t                              bus;
  logic [NUM_DIGITS-1:0][SEG_W-1:0]  seg_q;

  // assert at once, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  // index 0 is written first
  assign bcd_vec = {unit_bcd, tens_bcd, hund_bcd};

  seg3_sequencer #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .bcd_i     (bcd_vec),
    .sel_bcd_o (sel_bcd),
    .bus_on_o  (bus_on),
    .strobe_o  (strobe),
    .done_o    (done)
  );

  seg3_encoder u_enc (
    .bcd_i   (sel_bcd),
    .blank_i (~bus_on),
    .seg_o   (bus)
  );

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    seg3_hold_reg u_hold (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .strobe_i (strobe[d]),
      .bus_i    (bus),
      .q_o      (seg_q[d])
    );
  end

  assign hund_seg = seg_q[0];
  assign tens_seg = seg_q[1];
  assign unit_seg = seg_q[2];

  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|strobe) |-> $stable(bus));

  // R1
  spare_bit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(hund_seg[7] || tens_seg[7] || unit_seg[7]));
endmodule

// File: tb/seg3_latch_updater_test.sv
`timescale 1ns/1ps
module seg3_latch_updater_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] h_in, t_in, u_in;
  logic [7:0] h_seg, t_seg, u_seg;
  logic       done;

  typedef struct packed { logic [7:0] h, t, u; } trip_t;

  trip_t      sb_q[$];
  trip_t      mon_e;
  int         checks = 0;
  int         errors = 0;
  int         done_seen = 0;
  int         done_exp = 0;
  bit         finished = 0;
  logic [7:0] cur_h, cur_t, cur_u;

  always #2.5 clk = ~clk;

  seg3_latch_updater uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .hund_bcd(h_in), .tens_bcd(t_in), .unit_bcd(u_in),
    .hund_seg(h_seg), .tens_seg(t_seg), .unit_seg(u_seg), .done(done)
  );

  // R1, R2 expected patterns
  function automatic logic [7:0] exp_seg(input logic [3:0] d);
    case (d)
      4'd0: return 8'h3F;
      4'd1: return 8'h06;
      4'd2: return 8'h5B;
      4'd3: return 8'h4F;
      4'd4: return 8'h66;
      4'd5: return 8'h6D;
      4'd6: return 8'h7D;
      4'd7: return 8'h07;
      4'd8: return 8'h7F;
      4'd9: return 8'h6F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      done_seen++;
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 unexpected done actual=1 expected=0");
      end else begin
        mon_e = sb_q.pop_front();
        chk("R1/R2 hundreds at done", h_seg, mon_e.h);
        chk("R1/R2 tens at done", t_seg, mon_e.t);
        chk("R1/R2 units at done", u_seg, mon_e.u);
      end
    end
  end

  // driver: one full pass with cycle-exact checks
  task automatic run_seq(input logic [3:0] h, input logic [3:0] t,
                         input logic [3:0] u, input bit inject);
    trip_t e;
    e.h = exp_seg(h); e.t = exp_seg(t); e.u = exp_seg(u);
    sb_q.push_back(e);
    done_exp++;
    @(negedge clk);
    start = 1'b1; h_in = h; t_in = t; u_in = u;
    @(negedge clk);                              // after E0
    start = 1'b0; h_in = ~h; t_in = ~t; u_in = ~u;   // R10 scramble
    @(negedge clk);                              // after E1
    chk("R3 hundreds not yet written", h_seg, cur_h);
    @(negedge clk);                              // after E2
    chk("R3 hundreds loaded", h_seg, e.h);
    chk("R5 tens untouched", t_seg, cur_t);
    chk("R5 units untouched", u_seg, cur_u);
    @(negedge clk);                              // after E3
    if (inject) begin
      start = 1'b1; h_in = h ^ 4'h5; t_in = t ^ 4'h3; u_in = u ^ 4'h6;   // R8
    end
    @(negedge clk);                              // after E4, tens strobe high
    start = 1'b0;
    chk("R5 tens held while bus carries tens data", t_seg, cur_t);
    chk("R4 hundreds kept", h_seg, e.h);
    @(negedge clk);                              // after E5
    chk("R3 tens loaded", t_seg, e.t);
    chk("R5 units untouched", u_seg, cur_u);
    @(negedge clk);                              // after E6
    @(negedge clk);                              // after E7
    chk("R4 hundreds kept during units", h_seg, e.h);
    chk("R4 tens kept during units", t_seg, e.t);
    chk("R5 units held before strobe", u_seg, cur_u);
    @(negedge clk);                              // after E8
    chk("R3 units loaded", u_seg, e.u);
    chk("R9 done not early", {7'b0, done}, 8'h00);
    @(negedge clk);                              // after E9
    chk("R9 done pulse", {7'b0, done}, 8'h01);
    @(negedge clk);                              // after E10
    chk("R9 done one cycle", {7'b0, done}, 8'h00);
    cur_h = e.h; cur_t = e.t; cur_u = e.u;
    if (inject) begin
      repeat (12) @(negedge clk);
      chk("R8 no extra pass", 8'(done_seen), 8'(done_exp));
      chk("R8 hundreds unchanged", h_seg, cur_h);
      chk("R8 tens unchanged", t_seg, cur_t);
      chk("R8 units unchanged", u_seg, cur_u);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; h_in = '0; t_in = '0; u_in = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset hundreds", h_seg, 8'h00);
    chk("R7 reset tens", t_seg, 8'h00);
    chk("R7 reset units", u_seg, 8'h00);
    chk("R7 reset done", {7'b0, done}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_h = 8'h00; cur_t = 8'h00; cur_u = 8'h00;

    run_seq(4'd1, 4'd2, 4'd3, 1'b0);
    run_seq(4'd4, 4'd5, 4'd6, 1'b0);
    run_seq(4'd7, 4'd8, 4'd9, 1'b1);
    run_seq(4'd0, 4'd8, 4'd6, 1'b0);
    run_seq(4'd10, 4'd12, 4'd15, 1'b0);   // R2
    run_seq(4'd11, 4'd13, 4'd14, 1'b0);   // R2
    for (int d = 0; d < 16; d++) begin    // R1 full table
      run_seq(4'(d), 4'((d + 3) % 16), 4'((d + 7) % 16), 1'b0);
    end

    // R7 hold while idle with moving inputs
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      h_in = 4'(k); t_in = 4'(k * 3); u_in = 4'(k * 7);
    end
    chk("R7 idle hold hundreds", h_seg, cur_h);
    chk("R7 idle hold tens", t_seg, cur_t);
    chk("R7 idle hold units", u_seg, cur_u);

    // R7 reset in the middle of a pass
    @(negedge clk);
    start = 1'b1; h_in = 4'd5; t_in = 4'd2; u_in = 4'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 async clear hundreds", h_seg, 8'h00);
    chk("R7 async clear tens", t_seg, 8'h00);
    chk("R7 async clear units", u_seg, 8'h00);
    chk("R7 async clear done", {7'b0, done}, 8'h00);
    sb_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 stays clear after release", h_seg | t_seg | u_seg, 8'h00);
    chk("R9 no done after abort", 8'(done_seen), 8'(done_exp));
    cur_h = 8'h00; cur_t = 8'h00; cur_u = 8'h00;

    run_seq(4'd3, 4'd1, 4'd4, 1'b0);
    finish_run();
  end
endmodule